// File: doc/BRIEF.md
# Power-Good and Fault Protection Supervisor

This block watches the output of a switching regulator and decides when the output counts as good. It also decides how the regulator reacts to three kinds of fault. It works on digitised inputs: a sensed output code, the target code, a load-current code and a die-temperature code. It also takes the enable and supply-valid levels, a soft-start "near target" flag and a "first switching pulse seen" flag. Register fields select the thresholds. From these it drives a registered power-good output, force-off requests for the control and synchronous FETs, a force-on request for the synchronous FET, and a soft-start reset.

A single state machine holds the fault policy. Its states are OFF (not enabled, or supply not valid), RUN (regulating), OVP_LATCH (over-voltage trip, latched), OCP_DRAIN (over-current trip, sync FET held on until the current reaches zero), OCP_BLANK (hiccup blanking with both FETs off) and OTP_WAIT (thermal shutdown).

The named transitions are:
- OFF->RUN when enable and supply are both valid.
- Any state->OFF when either is lost.
- RUN->OVP_LATCH, OCP_DRAIN->OVP_LATCH, OCP_BLANK->OVP_LATCH and OTP_WAIT->OVP_LATCH on a qualified over-voltage.
- RUN->OCP_DRAIN on over-current.
- RUN->OTP_WAIT on over-temperature.
- OCP_DRAIN->OCP_BLANK at zero current.
- OCP_BLANK->RUN (retry) after the blanking count.
- OTP_WAIT->RUN once the die has cooled.

The OVP qualification delay and the hiccup blanking time are counted in clock cycles, and both are set by parameters.

Top module: `pgfault_sup`

## Requirements
- R1: While reset is held, or whenever enable or supply-valid is low at a clock edge, the next cycle shows `pg_o`=0 with `ctl_off_o`, `sync_off_o` and `ss_reset_o` all at 1 and `sync_on_o`=0 (state OFF). From OFF, the block enters RUN one edge after both levels are high. In RUN all four FET and soft-start outputs are 0.
- R2: `cfg_pg_sel` values 0,1,2,3 set the rising power-good level to 80, 85, 90 and 95 % of the target. The falling level is 5 points lower. A low PG goes high only when sense*100 > target*rise%. A high PG goes low only when sense*100 < target*(rise%-5). PG is registered, so it reflects the inputs sampled at the previous edge.
- R3: With `cfg_pg_mode`=0, the start-up phase begins on each entry to RUN and lasts until PG first goes high. During this phase PG follows `ss_near_i` instead of the voltage level. After the phase ends, and at all times with `cfg_pg_mode`=1, the level rule of R2 applies.
- R4: After each entry to RUN, PG stays low until `sw_started_i` has been sampled high at an edge while in RUN. This handles a pre-biased output.
- R5: `cfg_ovp_sel` values 0..3 set the over-voltage level to 105, 110, 115 and 120 % of the target. "Above" means sense*100 > target*level%. The block moves to OVP_LATCH at the OVP_DLY_CYC-th consecutive edge at which the sense is above (not counting edges in OFF). While the sense is above, PG goes low even before the trip.
- R6: In OVP_LATCH, `ctl_off_o`=1 and `ss_reset_o`=1. The sync FET is forced on at entry. It is forced off (`sync_off_o`) once the sense falls below target*(level%-5), and forced on again if the sense rises above the level. Only OFF leaves OVP_LATCH.
- R7: `cfg_ocp_sel` values 0, 1 and 2 (and 3) set the current limit to 64, 96 and 128 (and 128) in a current code of 1/16 A per LSB. When `cur_i` exceeds the limit in RUN, the block enters OCP_DRAIN, with `sync_on_o`=1 and `ctl_off_o`=1. At the first edge with `cur_i`=0 it enters OCP_BLANK, with both FETs forced off for BLANK_CYC cycles. It then returns to RUN and trips again while the fault persists.
- R8: `cfg_otp_sel` values 0..3 set the thermal limit to 75, 85, 125 and 145 in a temperature code of 1 °C per LSB. When `temp_i` exceeds the limit in RUN, the block enters OTP_WAIT, with both FETs forced off and soft-start reset. It returns to RUN when `temp_i` < limit-20.
- R9: On faults that fire together, OVP outranks OCP, and OCP outranks OTP. From RUN, a simultaneous over-current and over-temperature select OCP_DRAIN. A qualified over-voltage in OCP_DRAIN, OCP_BLANK or OTP_WAIT moves the block to OVP_LATCH.
- R10: PG is low in every cycle where the state is not RUN, and it drops in the cycle after any edge that leaves RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Regulator enable level |
| supply_ok_i | input | 1 | Bias supply above its start level |
| vsense_i | input | CODE_W | Digitised sensed output voltage |
| vtarget_i | input | CODE_W | Target output voltage code |
| cur_i | input | CUR_W | Load current code, 1/16 A per LSB |
| temp_i | input | TEMP_W | Die temperature code, 1 °C per LSB |
| ss_near_i | input | 1 | Soft-start ramp within 98 % of target |
| sw_started_i | input | 1 | First control-FET pulse has occurred |
| cfg_pg_sel | input | 2 | Power-good level select |
| cfg_pg_mode | input | 2 | 0: soft-start flag during start-up, 1: level always (bit 0 used) |
| cfg_ovp_sel | input | 2 | Over-voltage level select |
| cfg_ocp_sel | input | 2 | Current limit select |
| cfg_otp_sel | input | 2 | Thermal limit select |
| pg_o | output | 1 | Power good |
| ctl_off_o | output | 1 | Force control FET off |
| sync_off_o | output | 1 | Force sync FET off |
| sync_on_o | output | 1 | Force sync FET on |
| ss_reset_o | output | 1 | Reset soft-start |

## Verification
The bound checker runs every cycle and covers the relations that hold whatever the stimulus:
- loss of enable or supply turns everything off in the next cycle;
- PG is never high while the control FET is held off, and can only rise after a cycle in which enable and supply were valid;
- forcing the sync FET on always coincides with the control FET being off;
- a discharging or draining state keeps the control FET off in the following cycle.

Only the bench scenarios can show the rest:
- the exact OVP dwell count and the hiccup blanking length;
- the threshold and hysteresis values for each select code;
- the start-up mode difference and the pre-bias hold;
- the priority order when faults coincide.

In these scenarios a behavioural model is compared against the block on every clock.

// File: rtl/pgfault_pkg.sv
package pgfault_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RUN,
        ST_OVP_LATCH,
        ST_OCP_DRAIN,
        ST_OCP_BLANK,
        ST_OTP_WAIT
    } sup_state_t;

    // Levels in twentieths of the target (5 % steps).
    function automatic logic [4:0] pg_rise_k(input logic [1:0] sel);
        return 5'd16 + {3'd0, sel};
    endfunction

    function automatic logic [4:0] ovp_trip_k(input logic [1:0] sel);
        return 5'd21 + {3'd0, sel};
    endfunction

    // Current limit in 1/16 A steps.
    function automatic logic [7:0] oc_limit(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'd64;
            2'd1:    return 8'd96;
            default: return 8'd128;
        endcase
    endfunction

    // Thermal limit in degrees.
    function automatic logic [7:0] ot_limit(input logic [1:0] sel);
        case (sel)
            2'd0:    return 8'd75;
            2'd1:    return 8'd85;
            2'd2:    return 8'd125;
            default: return 8'd145;
        endcase
    endfunction

endpackage

// File: rtl/pgfault_vwin.sv
module pgfault_vwin #(
    parameter int CODE_W = 10
) (
    input  logic [CODE_W-1:0] sense,
    input  logic [CODE_W-1:0] target,
    input  logic [1:0]        pg_sel,
    input  logic [1:0]        ovp_sel,
    output logic              pg_rise,
    output logic              pg_fall,
    output logic              ov_above,
    output logic              ov_release
);
    localparam int PW = CODE_W + 5;

    logic [PW-1:0] sense_x20;
    logic [PW-1:0] pg_hi_lvl, pg_lo_lvl, ov_hi_lvl, ov_lo_lvl;
    logic [4:0]    pg_k, ov_k;

    assign pg_k = pgfault_pkg::pg_rise_k(pg_sel);
    assign ov_k = pgfault_pkg::ovp_trip_k(ovp_sel);

    assign sense_x20 = PW'({sense, 4'b0000}) + PW'({sense, 2'b00});
    assign pg_hi_lvl = PW'(target) * PW'(pg_k);
    assign pg_lo_lvl = PW'(target) * PW'(pg_k - 5'd1);
    assign ov_hi_lvl = PW'(target) * PW'(ov_k);
    assign ov_lo_lvl = PW'(target) * PW'(ov_k - 5'd1);

    assign pg_rise    = sense_x20 > pg_hi_lvl;
    assign pg_fall    = sense_x20 < pg_lo_lvl;
    assign ov_above   = sense_x20 > ov_hi_lvl;
    assign ov_release = sense_x20 < ov_lo_lvl;
endmodule

// File: rtl/pgfault_dwell.sv
module pgfault_dwell #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/pgfault_sup.sv
module pgfault_sup
    import pgfault_pkg::*;
#(
    parameter int CODE_W      = 10,
    parameter int CUR_W       = 8,
    parameter int TEMP_W      = 8,
    parameter int OVP_DLY_CYC = 500,
    parameter int BLANK_CYC   = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              supply_ok_i,
    input  logic [CODE_W-1:0] vsense_i,
    input  logic [CODE_W-1:0] vtarget_i,
    input  logic [CUR_W-1:0]  cur_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic              ss_near_i,
    input  logic              sw_started_i,
    input  logic [1:0]        cfg_pg_sel,
    input  logic [1:0]        cfg_pg_mode,
    input  logic [1:0]        cfg_ovp_sel,
    input  logic [1:0]        cfg_ocp_sel,
    input  logic [1:0]        cfg_otp_sel,
    output logic              pg_o,
    output logic              ctl_off_o,
    output logic              sync_off_o,
    output logic              sync_on_o,
    output logic              ss_reset_o
);
    sup_state_t state_q, state_d;
    logic pg_q, pg_d, startup_q, seen_q, dis_q;
    logic pg_rise, pg_fall, ov_above, ov_release;
    logic ovp_trip, blank_done, oc_trip, ot_trip, ot_clear, live, lvl_ok;
    logic [CUR_W-1:0]  oc_lim;
    logic [TEMP_W-1:0] ot_lim;

    pgfault_vwin #(.CODE_W(CODE_W)) vwin_i (
        .sense(vsense_i), .target(vtarget_i),
        .pg_sel(cfg_pg_sel), .ovp_sel(cfg_ovp_sel),
        .pg_rise(pg_rise), .pg_fall(pg_fall),
        .ov_above(ov_above), .ov_release(ov_release)
    );

    pgfault_dwell #(.LIMIT(OVP_DLY_CYC)) ovp_dly_i (
        .clk(clk), .rst_n(rst_n),
        .run(ov_above && (state_q != ST_OFF)), .done(ovp_trip)
    );

    pgfault_dwell #(.LIMIT(BLANK_CYC)) blank_i (
        .clk(clk), .rst_n(rst_n),
        .run(state_q == ST_OCP_BLANK), .done(blank_done)
    );

    assign live     = en_i && supply_ok_i;
    assign oc_lim   = CUR_W'(oc_limit(cfg_ocp_sel));
    assign ot_lim   = TEMP_W'(ot_limit(cfg_otp_sel));
    assign oc_trip  = cur_i > oc_lim;
    assign ot_trip  = temp_i > ot_lim;
    assign ot_clear = temp_i < (ot_lim - TEMP_W'(20));

    // Next-state decision, OVP > OCP > OTP.
    always_comb begin
        state_d = state_q;
        if (!live) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:       state_d = ST_RUN;
                ST_RUN: begin
                    if (ovp_trip)     state_d = ST_OVP_LATCH;
                    else if (oc_trip) state_d = ST_OCP_DRAIN;
                    else if (ot_trip) state_d = ST_OTP_WAIT;
                end
                ST_OCP_DRAIN: begin
                    if (ovp_trip)          state_d = ST_OVP_LATCH;
                    else if (cur_i == '0)  state_d = ST_OCP_BLANK;
                end
                ST_OCP_BLANK: begin
                    if (ovp_trip)        state_d = ST_OVP_LATCH;
                    else if (blank_done) state_d = ST_RUN;
                end
                ST_OTP_WAIT: begin
                    if (ovp_trip)      state_d = ST_OVP_LATCH;
                    else if (ot_clear) state_d = ST_RUN;
                end
                ST_OVP_LATCH: state_d = ST_OVP_LATCH;
            endcase
        end
    end

    // Power-good qualification.
    always_comb begin
        if (!cfg_pg_mode[0] && startup_q)
            lvl_ok = ss_near_i;
        else if (pg_q)
            lvl_ok = !pg_fall;
        else
            lvl_ok = pg_rise;
        pg_d = (state_q == ST_RUN) && (state_d == ST_RUN) &&
               !ov_above && seen_q && lvl_ok;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            pg_q      <= 1'b0;
            startup_q <= 1'b1;
            seen_q    <= 1'b0;
            dis_q     <= 1'b1;
        end else begin
            state_q   <= state_d;
            pg_q      <= pg_d;
            startup_q <= (state_q != ST_RUN) ? 1'b1 : (startup_q && !pg_d);
            seen_q    <= (state_q != ST_RUN) ? 1'b0 : (seen_q || sw_started_i);
            if (state_q != ST_OVP_LATCH) dis_q <= 1'b1;
            else if (ov_above)           dis_q <= 1'b1;
            else if (ov_release)         dis_q <= 1'b0;
        end
    end

    // Output decode.
    always_comb begin
        pg_o       = pg_q;
        ctl_off_o  = 1'b1;
        sync_off_o = 1'b0;
        sync_on_o  = 1'b0;
        ss_reset_o = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                ctl_off_o  = 1'b0;
                ss_reset_o = 1'b0;
            end
            ST_OVP_LATCH: begin
                sync_on_o  = dis_q;
                sync_off_o = !dis_q;
            end
            ST_OCP_DRAIN: sync_on_o  = 1'b1;
            ST_OFF, ST_OCP_BLANK, ST_OTP_WAIT: sync_off_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/pgfault_sup_chk.sv
module pgfault_sup_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic supply_ok_i,
    input logic pg_o,
    input logic ctl_off_o,
    input logic sync_on_o
);
    assert_off_on_loss_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_i && supply_ok_i) |=> (ctl_off_o && !pg_o && !sync_on_o));

    assert_pg_needs_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_o) |-> $past(en_i && supply_ok_i));

    assert_pg_only_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pg_o |-> !ctl_off_o);

    assert_sync_on_ctl_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sync_on_o |-> ctl_off_o);

    assert_latched_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_on_o && en_i && supply_ok_i) |=> ctl_off_o);
endmodule

bind pgfault_sup pgfault_sup_chk chk_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .supply_ok_i(supply_ok_i),
    .pg_o(pg_o), .ctl_off_o(ctl_off_o), .sync_on_o(sync_on_o)
);

// File: tb/pgfault_sup_tb_top.sv
module pgfault_sup_tb_top;
    localparam int CW  = 10;
    localparam int DLY = 4;
    localparam int BLK = 20;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, en, sup, ss_near, sw;
    logic [CW-1:0] sense, target;
    logic [7:0] cur, temp;
    logic [1:0] pg_sel, pg_mode, ovp_sel, ocp_sel, otp_sel;
    logic pg, ctl_off, sync_off, sync_on, ss_reset;

    pgfault_sup #(.CODE_W(CW), .CUR_W(8), .TEMP_W(8),
                  .OVP_DLY_CYC(DLY), .BLANK_CYC(BLK)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .supply_ok_i(sup),
        .vsense_i(sense), .vtarget_i(target), .cur_i(cur), .temp_i(temp),
        .ss_near_i(ss_near), .sw_started_i(sw),
        .cfg_pg_sel(pg_sel), .cfg_pg_mode(pg_mode), .cfg_ovp_sel(ovp_sel),
        .cfg_ocp_sel(ocp_sel), .cfg_otp_sel(otp_sel),
        .pg_o(pg), .ctl_off_o(ctl_off), .sync_off_o(sync_off),
        .sync_on_o(sync_on), .ss_reset_o(ss_reset)
    );

    int vectors = 0, miscompares = 0;
    bit finished = 0;
    string tag = "R1 reset";

    // Behavioural model: 0 off, 1 run, 2 ovp, 3 drain, 4 blank, 5 otp
    int m_st = 0, m_ovc = 0, m_blk = 0, m_pg = 0, m_start = 1, m_seen = 0, m_dis = 1;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_ovc = 0; m_blk = 0; m_pg = 0; m_start = 1; m_seen = 0; m_dis = 1;
        end else begin
            int s100, t, ovl, pgl, ocl, otl, nx, npg, lvl;
            bit above, rel, live, trip, bdone;
            s100 = int'(sense) * 100;
            t    = int'(target);
            ovl  = 105 + 5 * int'(ovp_sel);
            pgl  = 80 + 5 * int'(pg_sel);
            ocl  = (ocp_sel == 0) ? 64 : (ocp_sel == 1) ? 96 : 128;
            otl  = (otp_sel == 0) ? 75 : (otp_sel == 1) ? 85 : (otp_sel == 2) ? 125 : 145;
            above = s100 > t * ovl;
            rel   = s100 < t * (ovl - 5);
            live  = en && sup;
            trip  = above && (m_st != 0) && (m_ovc == DLY - 1);
            bdone = (m_st == 4) && (m_blk == BLK - 1);
            nx = m_st;
            if (!live) nx = 0;
            else if (m_st == 0) nx = 1;
            else if (m_st == 2) nx = 2;
            else if (trip) nx = 2;
            else if (m_st == 1) begin
                if (int'(cur) > ocl) nx = 3;
                else if (int'(temp) > otl) nx = 5;
            end else if (m_st == 3) begin
                if (cur == 0) nx = 4;
            end else if (m_st == 4) begin
                if (bdone) nx = 1;
            end else if (m_st == 5) begin
                if (int'(temp) < otl - 20) nx = 1;
            end
            if (pg_mode[0] == 1'b0 && m_start == 1) lvl = int'(ss_near);
            else if (m_pg == 1) lvl = (s100 < t * (pgl - 5)) ? 0 : 1;
            else lvl = (s100 > t * pgl) ? 1 : 0;
            npg = (m_st == 1 && nx == 1 && !above && m_seen == 1 && lvl == 1) ? 1 : 0;
            if (m_st != 1) begin m_start = 1; m_seen = 0; end
            else begin
                if (npg == 1) m_start = 0;
                if (sw) m_seen = 1;
            end
            if (m_st != 2) m_dis = 1;
            else if (above) m_dis = 1;
            else if (rel) m_dis = 0;
            m_ovc = (above && m_st != 0) ? ((m_ovc < DLY - 1) ? m_ovc + 1 : m_ovc) : 0;
            m_blk = (m_st == 4) ? ((m_blk < BLK - 1) ? m_blk + 1 : m_blk) : 0;
            m_pg = npg;
            m_st = nx;
        end
    end

    task automatic cmp(string nm, logic act, int exp);
        vectors++;
        if (act !== exp[0]) begin
            miscompares++;
            $display("FAIL %s %s actual=%0b expected=%0d", tag, nm, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            cmp("pg_o",       pg,       m_pg);
            cmp("ctl_off_o",  ctl_off,  (m_st != 1) ? 1 : 0);
            cmp("sync_on_o",  sync_on,  ((m_st == 2 && m_dis == 1) || m_st == 3) ? 1 : 0);
            cmp("sync_off_o", sync_off, (m_st == 0 || m_st == 4 || m_st == 5 ||
                                         (m_st == 2 && m_dis == 0)) ? 1 : 0);
            cmp("ss_reset_o", ss_reset, (m_st != 1) ? 1 : 0);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_sw();
        sw = 1'b1; tick(1); sw = 1'b0;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 0; en = 0; sup = 0; sense = 0; target = 400; cur = 0; temp = 25;
        ss_near = 0; sw = 0; pg_sel = 2; pg_mode = 2'd1; ovp_sel = 3; ocp_sel = 2; otp_sel = 3;
        tag = "R1 reset"; tick(3); rst_n = 1; tick(3);
        en = 1; tick(3);

        tag = "R4 prebias hold"; sup = 1; sense = 400; tick(8); pulse_sw(); tick(5);

        tag = "R2 level hysteresis";
        sense = 350; tick(4); sense = 335; tick(4); sense = 350; tick(4); sense = 365; tick(4);
        pg_sel = 0; sense = 310; tick(3); sense = 295; tick(3); sense = 325; tick(3);
        pg_sel = 3; sense = 370; tick(3); sense = 355; tick(3); sense = 385; tick(3);
        pg_sel = 2; sense = 400; tick(3);

        tag = "R3 startup mode";
        en = 0; tick(2); pg_mode = 2'd0; en = 1; tick(2); pulse_sw(); tick(5);
        ss_near = 1; tick(4); ss_near = 0; tick(4); sense = 330; tick(3);
        sense = 400; pg_mode = 2'd1; tick(4);

        tag = "R5 ovp dwell";
        sense = 490; tick(3); sense = 400; tick(4); sense = 490; tick(6);
        tag = "R6 ovp latch";
        sense = 470; tick(3); sense = 450; tick(3); sense = 490; tick(3); sense = 400; tick(5);
        en = 0; tick(2); en = 1; tick(1); pulse_sw(); tick(5);
        sup = 0; tick(2); sup = 1; tick(1); pulse_sw(); tick(5);

        tag = "R7 R10 ocp hiccup";
        ocp_sel = 1; cur = 100; tick(3); cur = 50; tick(3); cur = 0; tick(25);
        cur = 100; tick(3); cur = 0; tick(22); pulse_sw(); cur = 90; tick(4);
        ocp_sel = 3; cur = 129; tick(2); cur = 0; tick(23); pulse_sw(); tick(4);

        tag = "R8 R10 otp restart";
        otp_sel = 0; temp = 80; tick(3); temp = 60; tick(3); temp = 54; tick(3);
        pulse_sw(); tick(4); otp_sel = 3; temp = 25; tick(2);

        tag = "R9 fault priority";
        cur = 200; temp = 200; tick(3); sense = 490; tick(6);
        cur = 0; temp = 25; sense = 400; tick(3);
        en = 0; tick(2); en = 1; tick(2); pulse_sw(); tick(4);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule